// File: doc/BRIEF.md
# Nested Trap Entry Controller

This block carries out the hardware part of entering a trap handler in a processor that allows traps to nest. When a request arrives with a 9-bit trap type, the block does four things. It raises the trap level. It saves the interrupted context into a bank of registers selected by the new level. It puts the processor status word into a fixed handler state. For window traps, it moves the current window pointer to the window the handler must work on.

In the same clock edge it forms the handler fetch address and the address that follows it. The handler address is built from the trap base address, a flag that tells a first-level trap from a nested one, and the trap type. A one-cycle valid pulse marks the new addresses.

Synchronous traps save the address pair of the faulting instruction. Asynchronous traps save the pair after the instruction that was allowed to complete. A trap that arrives at the deepest permitted level does not save anything. Instead it sets a sticky error-mode output. A read port lets the surrounding core, or a test, view any saved level.

Top module: `tec_top`

## Requirements
- R1: After reset the trap level `tl_o` is 0. Each accepted trap raises it by exactly 1.
- R2: An accepted trap writes to level L = old level + 1. It stores {ccr, asi, pstate, cwp} as tstate, with cwp in the least significant bits and ccr in the most significant bits. It also stores the trap type. The stored value is the pre-trap pstate and cwp.
- R3: For a synchronous trap (`trap_async`=0), the saved pair is (`cur_pc`, `cur_npc`). For an asynchronous trap it is (`cur_npc`, `cur_nnpc`).
- R4: The pstate bit positions are: AG=0, IE=1, PRIV=2, AM=3, PEF=4, MM=6:5, TLE=7, CLE=8, RED=9. The new pstate keeps MM and TLE. It sets RED=0, AM=0, IE=0, PRIV=1 and AG=1. PEF equals the FPU-present parameter, and CLE takes the old TLE.
- R5: The new cwp, taken modulo NWIN, depends on the trap type. For 0x024 it is cwp+1. For 0x080–0x0BF it is cwp+cansave+2. For 0x0C0–0x0FF it is cwp−1. For any other type cwp is unchanged.
- R6: The new PC is {tba[63:15], N, tt[8:0], 5'b00000}, where N is 1 when the pre-trap level was above 0. The new nPC is the same value with its low five bits set to 00100.
- R7: A request that arrives when the level equals MAXTL stores nothing and produces no redirect. It leaves the level unchanged and sets `err_mode`. Once set, `err_mode` stays set and all later requests are ignored until reset.
- R8: `redir_vld` is high for exactly the one cycle after each accepted request. The new pc/npc, pstate and cwp appear in that same cycle.
- R9: A push to one level leaves the saved contents of every lower level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request; each high cycle is one request |
| trap_tt | input | 9 | Trap type |
| trap_async | input | 1 | 1 = asynchronous trap, 0 = synchronous |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address space identifier |
| cur_pstate | input | 10 | Current processor status word |
| cur_cwp | input | CW | Current window pointer |
| cur_cansave | input | CW | Current savable window count |
| cur_pc | input | AW | PC of the current instruction |
| cur_npc | input | AW | Next PC |
| cur_nnpc | input | AW | PC following the next PC |
| tba | input | AW | Trap base address |
| tl_o | output | TLW | Current trap level |
| pstate_o | output | 10 | Handler status word |
| cwp_o | output | CW | Handler window pointer |
| redir_vld | output | 1 | One-cycle redirect strobe |
| redir_pc | output | AW | Handler PC |
| redir_npc | output | AW | Handler next PC |
| err_mode | output | 1 | Sticky nesting-overflow flag |
| rd_lvl | input | TLW | Level to read back |
| rd_tstate | output | 29 | Saved {ccr,asi,pstate,cwp} at rd_lvl |
| rd_tpc | output | AW | Saved PC at rd_lvl |
| rd_tnpc | output | AW | Saved next PC at rd_lvl |
| rd_tt | output | 9 | Saved trap type at rd_lvl |

## Verification
The assertions check the following on every cycle:
- the level steps by one and never exceeds MAXTL;
- the redirect strobe follows acceptance by exactly one cycle;
- every redirect carries the forced privilege, interrupt and global bits and an aligned, paired vector;
- the error flag is sticky and freezes the level.

Only the bench scenarios can show the rest:
- the exact cwp arithmetic at each boundary of the trap-type ranges;
- the choice of saved address pair for synchronous and asynchronous traps;
- the nested flag inside the vector;
- that lower levels are left intact after deeper pushes.

// File: rtl/tec_pkg.sv
package tec_pkg;
    localparam int PS_W    = 10;
    localparam int PS_AG   = 0;
    localparam int PS_IE   = 1;
    localparam int PS_PRIV = 2;
    localparam int PS_AM   = 3;
    localparam int PS_PEF  = 4;
    localparam int PS_TLE  = 7;
    localparam int PS_CLE  = 8;
    localparam int PS_RED  = 9;
    localparam int TT_W    = 9;

    typedef enum logic [1:0] {WK_NONE, WK_CLEAN, WK_SPILL, WK_FILL} win_kind_e;

    function automatic win_kind_e classify_tt(input logic [TT_W-1:0] tt);
        if (tt == 9'h024)                       return WK_CLEAN;
        else if (tt[8:6] == 3'b010)             return WK_SPILL;
        else if (tt[8:6] == 3'b011)             return WK_FILL;
        else                                    return WK_NONE;
    endfunction
endpackage

// File: rtl/tec_cwp_adj.sv
module tec_cwp_adj
    import tec_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN)
) (
    input  logic [TT_W-1:0] tt,
    input  logic [CW-1:0]   cwp,
    input  logic [CW-1:0]   cansave,
    output logic [CW-1:0]   cwp_new
);
    // NWIN is a power of two, so truncation to CW bits is the modulo.
    always_comb begin
        unique case (classify_tt(tt))
            WK_CLEAN: cwp_new = cwp + CW'(1);
            WK_SPILL: cwp_new = cwp + cansave + CW'(2);
            WK_FILL:  cwp_new = cwp - CW'(1);
            default:  cwp_new = cwp;
        endcase
    end
endmodule

// File: rtl/tec_vec_gen.sv
module tec_vec_gen
    import tec_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [AW-1:0]   tba,
    input  logic            nested,
    input  logic [TT_W-1:0] tt,
    output logic [AW-1:0]   pc,
    output logic [AW-1:0]   npc
);
    always_comb begin
        pc  = {tba[AW-1:15], nested, tt, 5'b00000};
        npc = {tba[AW-1:15], nested, tt, 5'b00100};
    end
endmodule

// File: rtl/tec_tstack.sv
module tec_tstack
    import tec_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int LW    = 3,
    parameter int TS_W  = 29,
    parameter int AW    = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [LW-1:0]   wr_lvl,
    input  logic [TS_W-1:0] wr_tstate,
    input  logic [AW-1:0]   wr_tpc,
    input  logic [AW-1:0]   wr_tnpc,
    input  logic [TT_W-1:0] wr_tt,
    input  logic [LW-1:0]   rd_lvl,
    output logic [TS_W-1:0] rd_tstate,
    output logic [AW-1:0]   rd_tpc,
    output logic [AW-1:0]   rd_tnpc,
    output logic [TT_W-1:0] rd_tt
);
    logic [TS_W-1:0] ts_q  [DEPTH];
    logic [AW-1:0]   pc_q  [DEPTH];
    logic [AW-1:0]   npc_q [DEPTH];
    logic [TT_W-1:0] tt_q  [DEPTH];

    // Level k (1..DEPTH) lives in slot k-1.
    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (!rst_n) begin
                ts_q[k]  <= '0;
                pc_q[k]  <= '0;
                npc_q[k] <= '0;
                tt_q[k]  <= '0;
            end else if (we && wr_lvl == LW'(k + 1)) begin
                ts_q[k]  <= wr_tstate;
                pc_q[k]  <= wr_tpc;
                npc_q[k] <= wr_tnpc;
                tt_q[k]  <= wr_tt;
            end
        end
    end

    always_comb begin
        rd_tstate = '0;
        rd_tpc    = '0;
        rd_tnpc   = '0;
        rd_tt     = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_lvl == LW'(k + 1)) begin
                rd_tstate = ts_q[k];
                rd_tpc    = pc_q[k];
                rd_tnpc   = npc_q[k];
                rd_tt     = tt_q[k];
            end
        end
    end
endmodule

// File: rtl/tec_top.sv
module tec_top
    import tec_pkg::*;
#(
    parameter int NWIN    = 8,
    parameter int MAXTL   = 5,
    parameter int AW      = 64,
    parameter bit HAS_FPU = 1'b1,
    parameter int CW      = $clog2(NWIN),
    parameter int TLW     = $clog2(MAXTL + 1),
    parameter int TS_W    = 16 + PS_W + CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic [TT_W-1:0] trap_tt,
    input  logic            trap_async,
    input  logic [7:0]      cur_ccr,
    input  logic [7:0]      cur_asi,
    input  logic [PS_W-1:0] cur_pstate,
    input  logic [CW-1:0]   cur_cwp,
    input  logic [CW-1:0]   cur_cansave,
    input  logic [AW-1:0]   cur_pc,
    input  logic [AW-1:0]   cur_npc,
    input  logic [AW-1:0]   cur_nnpc,
    input  logic [AW-1:0]   tba,
    output logic [TLW-1:0]  tl_o,
    output logic [PS_W-1:0] pstate_o,
    output logic [CW-1:0]   cwp_o,
    output logic            redir_vld,
    output logic [AW-1:0]   redir_pc,
    output logic [AW-1:0]   redir_npc,
    output logic            err_mode,
    input  logic [TLW-1:0]  rd_lvl,
    output logic [TS_W-1:0] rd_tstate,
    output logic [AW-1:0]   rd_tpc,
    output logic [AW-1:0]   rd_tnpc,
    output logic [TT_W-1:0] rd_tt
);
    typedef struct packed {
        logic [TLW-1:0]  tl;
        logic            err;
        logic            vld;
        logic [AW-1:0]   pc;
        logic [AW-1:0]   npc;
        logic [PS_W-1:0] ps;
        logic [CW-1:0]   cwp;
    } ctl_t;

    ctl_t st_d, st_q;

    logic            accept_w;
    logic            ovf_w;
    logic [CW-1:0]   cwp_adj_w;
    logic [AW-1:0]   vec_pc_w;
    logic [AW-1:0]   vec_npc_w;
    logic [PS_W-1:0] ps_forced_w;

    tec_cwp_adj #(.NWIN(NWIN), .CW(CW)) u_cwp (
        .tt      (trap_tt),
        .cwp     (cur_cwp),
        .cansave (cur_cansave),
        .cwp_new (cwp_adj_w)
    );

    tec_vec_gen #(.AW(AW)) u_vec (
        .tba    (tba),
        .nested (st_q.tl != '0),
        .tt     (trap_tt),
        .pc     (vec_pc_w),
        .npc    (vec_npc_w)
    );

    tec_tstack #(.DEPTH(MAXTL), .LW(TLW), .TS_W(TS_W), .AW(AW)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (accept_w),
        .wr_lvl    (st_q.tl + TLW'(1)),
        .wr_tstate ({cur_ccr, cur_asi, cur_pstate, cur_cwp}),
        .wr_tpc    (trap_async ? cur_npc  : cur_pc),
        .wr_tnpc   (trap_async ? cur_nnpc : cur_npc),
        .wr_tt     (trap_tt),
        .rd_lvl    (rd_lvl),
        .rd_tstate (rd_tstate),
        .rd_tpc    (rd_tpc),
        .rd_tnpc   (rd_tnpc),
        .rd_tt     (rd_tt)
    );

    always_comb begin
        accept_w = trap_req && !st_q.err && (st_q.tl < TLW'(MAXTL));
        ovf_w    = trap_req && !st_q.err && (st_q.tl == TLW'(MAXTL));

        ps_forced_w          = cur_pstate;
        ps_forced_w[PS_RED]  = 1'b0;
        ps_forced_w[PS_PEF]  = HAS_FPU;
        ps_forced_w[PS_AM]   = 1'b0;
        ps_forced_w[PS_PRIV] = 1'b1;
        ps_forced_w[PS_IE]   = 1'b0;
        ps_forced_w[PS_AG]   = 1'b1;
        ps_forced_w[PS_CLE]  = cur_pstate[PS_TLE];

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (accept_w) begin
            st_d.tl  = st_q.tl + TLW'(1);
            st_d.vld = 1'b1;
            st_d.pc  = vec_pc_w;
            st_d.npc = vec_npc_w;
            st_d.ps  = ps_forced_w;
            st_d.cwp = cwp_adj_w;
        end
        if (ovf_w) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tl_o      = st_q.tl;
    assign pstate_o  = st_q.ps;
    assign cwp_o     = st_q.cwp;
    assign redir_vld = st_q.vld;
    assign redir_pc  = st_q.pc;
    assign redir_npc = st_q.npc;
    assign err_mode  = st_q.err;
endmodule

// File: rtl/tec_chk.sv
module tec_chk
    import tec_pkg::*;
#(
    parameter int MAXTL = 5,
    parameter int TLW   = 3,
    parameter int AW    = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_req,
    input logic [TLW-1:0]  tl_o,
    input logic [PS_W-1:0] pstate_o,
    input logic            redir_vld,
    input logic [AW-1:0]   redir_pc,
    input logic [AW-1:0]   redir_npc,
    input logic            err_mode
);
    AST_TL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !err_mode && tl_o < TLW'(MAXTL)) |=> (tl_o == $past(tl_o) + TLW'(1))); // R1

    AST_TL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tl_o <= TLW'(MAXTL)); // R7

    AST_VLD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !err_mode && tl_o < TLW'(MAXTL)) |=> redir_vld); // R8

    AST_VLD_ONLY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_req && !err_mode && tl_o < TLW'(MAXTL)) |=> !redir_vld); // R8

    AST_PS_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |-> (pstate_o[PS_PRIV] && pstate_o[PS_AG] && !pstate_o[PS_IE]
                       && !pstate_o[PS_AM] && !pstate_o[PS_RED])); // R4

    AST_VEC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |-> (redir_pc[4:0] == 5'b0 && redir_npc == (redir_pc | AW'(4)))); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |=> (err_mode && $stable(tl_o))); // R7

    AST_OVF_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && tl_o == TLW'(MAXTL)) |=> (err_mode && !redir_vld)); // R7
endmodule

bind tec_top tec_chk #(.MAXTL(MAXTL), .TLW(TLW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_req  (trap_req),
    .tl_o      (tl_o),
    .pstate_o  (pstate_o),
    .redir_vld (redir_vld),
    .redir_pc  (redir_pc),
    .redir_npc (redir_npc),
    .err_mode  (err_mode)
);

// File: tb/tb_tec_top.sv
`timescale 1ns/1ps
module tb_tec_top;
    localparam int NW    = 8;
    localparam int MAXTL = 5;
    localparam int AW    = 64;
    localparam int CW    = 3;
    localparam int TLW   = 3;
    localparam int PSW   = 10;
    localparam int TSW   = 16 + PSW + CW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_req = 1'b0;
    logic [8:0]      trap_tt = '0;
    logic            trap_async = 1'b0;
    logic [7:0]      cur_ccr = '0, cur_asi = '0;
    logic [PSW-1:0]  cur_pstate = '0;
    logic [CW-1:0]   cur_cwp = '0, cur_cansave = '0;
    logic [AW-1:0]   cur_pc = '0, cur_npc = '0, cur_nnpc = '0, tba = '0;
    logic [TLW-1:0]  tl_o, rd_lvl = '0;
    logic [PSW-1:0]  pstate_o;
    logic [CW-1:0]   cwp_o;
    logic            redir_vld, err_mode;
    logic [AW-1:0]   redir_pc, redir_npc, rd_tpc, rd_tnpc;
    logic [TSW-1:0]  rd_tstate;
    logic [8:0]      rd_tt;

    int n_chk = 0, n_err = 0;
    int m_tl = 0;
    bit m_err = 0;
    logic [TSW-1:0] l1_ts;
    logic [AW-1:0]  l1_pc;
    logic [8:0]     l1_tt;

    always #2.5 clk = ~clk;

    tec_top dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_tt(trap_tt),
        .trap_async(trap_async), .cur_ccr(cur_ccr), .cur_asi(cur_asi),
        .cur_pstate(cur_pstate), .cur_cwp(cur_cwp), .cur_cansave(cur_cansave),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_nnpc(cur_nnpc), .tba(tba),
        .tl_o(tl_o), .pstate_o(pstate_o), .cwp_o(cwp_o), .redir_vld(redir_vld),
        .redir_pc(redir_pc), .redir_npc(redir_npc), .err_mode(err_mode),
        .rd_lvl(rd_lvl), .rd_tstate(rd_tstate), .rd_tpc(rd_tpc),
        .rd_tnpc(rd_tnpc), .rd_tt(rd_tt)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, expv);
        end
    endtask

    function automatic logic [CW-1:0] e_cwp(input logic [8:0] tt, input int cwp, input int cs);
        if (tt == 9'h024)                      return CW'((cwp + 1) % NW);
        if (tt >= 9'h080 && tt <= 9'h0BF)      return CW'((cwp + cs + 2) % NW);
        if (tt >= 9'h0C0 && tt <= 9'h0FF)      return CW'((cwp + NW - 1) % NW);
        return CW'(cwp);
    endfunction

    function automatic logic [PSW-1:0] e_ps(input logic [PSW-1:0] p);
        logic [PSW-1:0] r;
        r = p;
        r[9] = 1'b0; r[4] = 1'b1; r[3] = 1'b0; r[2] = 1'b1;
        r[1] = 1'b0; r[0] = 1'b1; r[8] = p[7];
        return r;
    endfunction

    function automatic logic [AW-1:0] e_pc(input logic [AW-1:0] b, input int lvl, input logic [8:0] tt);
        logic [AW-1:0] r;
        r = b & ~64'h7FFF;
        r = r | (64'(lvl > 0) << 14) | (64'(tt) << 5);
        return r;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; trap_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_tl = 0; m_err = 0;
        @(negedge clk);
        chk(tl_o == 0, "R1 reset level", 64'(tl_o), 0);
        chk(!redir_vld && !err_mode, "R8 reset strobe/err", {62'b0, redir_vld, err_mode}, 0);
    endtask

    task automatic do_trap(input logic [8:0] tt, input bit as);
        logic [TSW-1:0] ts_exp;
        int prev;
        trap_tt = tt; trap_async = as;
        cur_ccr = 8'($urandom); cur_asi = 8'($urandom);
        cur_pstate = PSW'($urandom); cur_cwp = CW'($urandom); cur_cansave = CW'($urandom);
        cur_pc = {$urandom, $urandom}; cur_npc = {$urandom, $urandom};
        cur_nnpc = {$urandom, $urandom}; tba = {$urandom, $urandom};
        ts_exp = {cur_ccr, cur_asi, cur_pstate, cur_cwp};
        trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
        prev = m_tl;
        if (!m_err && m_tl < MAXTL) begin
            m_tl++;
            chk(tl_o == TLW'(m_tl), "R1 level step", 64'(tl_o), 64'(m_tl));
            chk(redir_vld, "R8 strobe", 64'(redir_vld), 1);
            chk(redir_pc == e_pc(tba, prev, tt), "R6 vector pc", redir_pc, e_pc(tba, prev, tt));
            chk(redir_npc == (e_pc(tba, prev, tt) | 64'h4), "R6 vector npc", redir_npc, e_pc(tba, prev, tt) | 64'h4);
            chk(pstate_o == e_ps(cur_pstate), "R4 pstate", 64'(pstate_o), 64'(e_ps(cur_pstate)));
            chk(cwp_o == e_cwp(tt, int'(cur_cwp), int'(cur_cansave)), "R5 cwp",
                64'(cwp_o), 64'(e_cwp(tt, int'(cur_cwp), int'(cur_cansave))));
            rd_lvl = TLW'(m_tl);
            #0.5;
            chk(rd_tstate == ts_exp, "R2 tstate", 64'(rd_tstate), 64'(ts_exp));
            chk(rd_tt == tt, "R2 tt", 64'(rd_tt), 64'(tt));
            chk(rd_tpc == (as ? cur_npc : cur_pc), "R3 tpc", rd_tpc, as ? cur_npc : cur_pc);
            chk(rd_tnpc == (as ? cur_nnpc : cur_npc), "R3 tnpc", rd_tnpc, as ? cur_nnpc : cur_npc);
            if (m_tl == 1) begin l1_ts = ts_exp; l1_pc = rd_tpc; l1_tt = tt; end
        end else begin
            m_err = 1;
            chk(err_mode, "R7 err set", 64'(err_mode), 1);
            chk(!redir_vld, "R7 no redirect", 64'(redir_vld), 0);
            chk(tl_o == TLW'(m_tl), "R7 level held", 64'(tl_o), 64'(m_tl));
        end
        @(negedge clk);
        chk(!redir_vld, "R8 single pulse", 64'(redir_vld), 0);
    endtask

    task automatic chk_level1();
        rd_lvl = TLW'(1);
        #0.5;
        chk(rd_tstate == l1_ts && rd_tt == l1_tt, "R9 level1 tstate/tt", 64'(rd_tstate), 64'(l1_ts));
        chk(rd_tpc == l1_pc, "R9 level1 tpc", rd_tpc, l1_pc);
    endtask

    function automatic logic [8:0] rand_tt();
        case ($urandom % 4)
            0: return 9'h024;
            1: return 9'h080 + 9'($urandom % 64);
            2: return 9'h0C0 + 9'($urandom % 64);
            default: return 9'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd7741));
        do_reset();
        // directed range boundaries (R5) and sync/async pair (R3)
        do_trap(9'h07F, 1'b0);
        do_trap(9'h080, 1'b1);
        do_trap(9'h0BF, 1'b0);
        do_trap(9'h0C0, 1'b1);
        do_trap(9'h0FF, 1'b0);
        do_trap(9'h100, 1'b0);   // overflow attempt at MAXTL (R7)
        do_trap(9'h024, 1'b1);   // ignored while in error mode (R7)
        chk_level1();
        do_reset();
        do_trap(9'h024, 1'b0);
        do_trap(9'h1FF, 1'b1);
        do_trap(9'h023, 1'b0);
        chk_level1();
        for (int r = 0; r < 60; r++) begin
            do_reset();
            for (int t = 0, n = 1 + ($urandom % 7); t < n; t++)
                do_trap(rand_tt(), 1'($urandom));
            chk_level1();
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule